// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm and Interrupts

This block is a real-time clock peripheral. It keeps a time of day as seconds, minutes and hours, plus a free-running 32-bit day count. The count advances once per second. A prescaler divides the system clock by `CLK_HZ` to produce that second strobe. Software reaches the block through a 32-bit word register port. Reads are combinational and writes take effect at the clock edge. The current time is read field by field or as one packed word. It is set through a separate group of write-only load registers.

A time-of-day alarm compares hour, minute and second with three alarm registers after each tick. Second, minute, hour, day and alarm events each set a bit in a write-one-to-clear status register, when the matching control bit enables that event. Six interrupt outputs follow the pending bits that are also enabled. A level output shows the alarm. Five one-cycle pulses are re-emitted after every tick and after every status write, one for each bit that is still pending and enabled.

The prescaler is a two-state machine. `PS_IDLE` waits with the counter held at zero. The transition *start* (control write with the run bit set) enters `PS_COUNT`. In `PS_COUNT`:
- *restart* (another such write) reloads the counter.
- *wrap* (counter at `CLK_HZ-1`) issues the tick and returns the counter to zero.
- *stop* (run bit clear) returns to `PS_IDLE`.

Top module: `rtc_core`

## Requirements
- R1: After `rst_n` is asserted, these registers read zero: time (0x00 seconds, 0x04 minutes, 0x08 hours, 0x0C days), alarm (0x10 seconds, 0x14 minutes, 0x18 hours), control (0x20) and status (0x34). All six interrupt outputs are low.
- R2: A one-cycle pulse on `tod_clear` zeroes the time and alarm registers and leaves control and status unchanged.
- R3: A write to control 0x20 with bit 0 set produces the first tick exactly `CLK_HZ` cycles after the write edge, and a tick every `CLK_HZ` cycles after that. With bit 0 clear, no tick occurs.
- R4: On each tick, seconds increment. A seconds value of 59 or above wraps to 0 and carries into minutes. Minutes wrap the same way at 59 or above and carry into hours. Hours wrap at 23 or above and carry into the 32-bit day count, which wraps from 0xFFFFFFFF to 0.
- R5: The load registers 0x24 (seconds), 0x28 (minutes), 0x2C (hours) and 0x30 (days) write the low bits of the data into the field: 6, 6, 5 and 32 bits. They read as zero. A load in the same cycle as a tick takes the loaded value for that field.
- R6: On a tick, status bits 0 to 3 are set for the second, minute, hour and day events only when the event occurs and control bits 1 to 4 respectively are set.
- R7: When control bit 5 is set and the post-tick hour, minute and second equal the alarm registers, status bit 4 is set. With bit 5 clear it is not set.
- R8: A write to status 0x34 clears each bit written as 1. An event set in the same cycle wins over the clear.
- R9: `irq_alarm_lvl` equals status bit 4 AND control bit 5.
- R10: In the cycle after a tick edge or a status-write edge, each output pulses for one cycle if its status bit is set and its enable bit is set. The pulse outputs are `irq_sec`, `irq_min`, `irq_hour`, `irq_day` and `irq_alarm_pls`. Their status bits are 0 to 4 and their enable bits are control bits 1 to 5.
- R11: Offset 0x44 reads (day<<17)|(hour<<12)|(minute<<6)|second, truncated to 32 bits. Offset 0x3C reads 0x00010000. Unmapped offsets read zero. Writes to read-only and unmapped offsets change nothing.
- R12: The alarm registers store and read back the low 8 bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous full reset, active low |
| tod_clear | input | 1 | Synchronous clear of time and alarm only |
| bus_addr | input | ADDR_W | Byte offset of the word accessed |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_alarm_lvl | output | 1 | Alarm pending and enabled (level) |
| irq_alarm_pls | output | 1 | Alarm pulse |
| irq_sec | output | 1 | Second-event pulse |
| irq_min | output | 1 | Minute-event pulse |
| irq_hour | output | 1 | Hour-event pulse |
| irq_day | output | 1 | Day-event pulse |

## Verification
Register reads are combinational, so the bench samples them half a nanosecond after setting the address, with the bus idle. A write becomes visible in the cycle after its edge. A tick lands on the edge `CLK_HZ` cycles after the control write. The bench counts exactly that many rising edges from the write edge, and it places collision writes on the edge just before the tick so that they coincide with it. Interrupt pulses are due in the single cycle after a tick edge or a status-write edge. The bench samples them one nanosecond after that edge and again one cycle later to confirm they have dropped. The level alarm is checked in the cycle after the edge that changes status or control.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int WORD_W   = 32;
    localparam int SEC_W    = 6;
    localparam int MIN_W    = 6;
    localparam int HOUR_W   = 5;
    localparam int DAY_W    = 32;
    localparam int SEC_MOD  = 60;
    localparam int MIN_MOD  = 60;
    localparam int HOUR_MOD = 24;
    localparam int ALM_W    = 8;

    localparam int EVT_N    = 5;
    localparam int CTRL_W   = EVT_N + 1;
    localparam int EV_SEC   = 0;
    localparam int EV_MIN   = 1;
    localparam int EV_HOUR  = 2;
    localparam int EV_DAY   = 3;
    localparam int EV_ALM   = 4;

    localparam int FLD_N    = 4;
    localparam int FLD_SEC  = 0;
    localparam int FLD_MIN  = 1;
    localparam int FLD_HOUR = 2;
    localparam int FLD_DAY  = 3;

    localparam int ALM_N    = 3;

    localparam int PK_MIN_SH  = 6;
    localparam int PK_HOUR_SH = 12;
    localparam int PK_DAY_SH  = 17;

    localparam logic [WORD_W-1:0] REV_WORD = 32'h0001_0000;

    localparam logic [7:0] OFS_SEC      = 8'h00;
    localparam logic [7:0] OFS_MIN      = 8'h04;
    localparam logic [7:0] OFS_HOUR     = 8'h08;
    localparam logic [7:0] OFS_DAY      = 8'h0C;
    localparam logic [7:0] OFS_ALM_SEC  = 8'h10;
    localparam logic [7:0] OFS_ALM_MIN  = 8'h14;
    localparam logic [7:0] OFS_ALM_HOUR = 8'h18;
    localparam logic [7:0] OFS_CTRL     = 8'h20;
    localparam logic [7:0] OFS_LD_SEC   = 8'h24;
    localparam logic [7:0] OFS_LD_MIN   = 8'h28;
    localparam logic [7:0] OFS_LD_HOUR  = 8'h2C;
    localparam logic [7:0] OFS_LD_DAY   = 8'h30;
    localparam logic [7:0] OFS_STATUS   = 8'h34;
    localparam logic [7:0] OFS_REV      = 8'h3C;
    localparam logic [7:0] OFS_PACKED   = 8'h44;

    typedef enum logic [0:0] {
        PS_IDLE  = 1'b0,
        PS_COUNT = 1'b1
    } ps_state_e;

    typedef struct packed {
        logic [DAY_W-1:0]  day;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } tod_t;

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale
    import rtc_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);

    localparam int CNT_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_HZ - 1);

    ps_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: start, restart, wrap, stop
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_IDLE: begin
                cnt_d = '0;
                if (restart_i) begin
                    state_d = PS_COUNT;
                end
            end
            PS_COUNT: begin
                if (restart_i) begin
                    cnt_d = '0;
                end else if (!run_i) begin
                    state_d = PS_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = PS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        tick_o = 1'b0;
        unique case (state_q)
            PS_IDLE:  tick_o = 1'b0;
            PS_COUNT: tick_o = run_i && !restart_i && (cnt_q == CNT_LAST);
            default:  tick_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_wrapctr.sv
module rtc_wrapctr #(
    parameter int W      = 6,
    parameter int MODULO = 60
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] val_o,
    output logic [W-1:0] next_o,
    output logic         carry_o
);

    logic [W-1:0] val_q, val_d;
    logic         at_top;

    generate
        if (MODULO > 0) begin : g_mod
            localparam logic [W:0] TOP = (W+1)'(MODULO - 1);
            assign at_top = ({1'b0, val_q} >= TOP);
        end else begin : g_free
            assign at_top = &val_q;
        end
    endgenerate

    assign carry_o = inc_i & at_top;

    always_comb begin
        val_d = val_q;
        if (ld_i) begin
            val_d = ld_val_i;
        end else if (inc_i) begin
            val_d = at_top ? '0 : val_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (clr_i) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign val_o  = val_q;
    assign next_o = val_d;

endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              tick_i,
    input  logic [FLD_N-1:0]  ld_en_i,
    input  logic [WORD_W-1:0] ld_val_i,
    input  logic [ALM_N-1:0]  alm_we_i,
    input  logic [ALM_W-1:0]  alm_val_i,
    input  logic              alm_en_i,
    output tod_t              tod_o,
    output logic [ALM_W-1:0]  alm_sec_o,
    output logic [ALM_W-1:0]  alm_min_o,
    output logic [ALM_W-1:0]  alm_hour_o,
    output logic [EVT_N-1:0]  evt_o
);

    logic              c_sec, c_min, c_hour, c_day;
    logic [SEC_W-1:0]  n_sec;
    logic [MIN_W-1:0]  n_min;
    logic [HOUR_W-1:0] n_hour;
    logic [DAY_W-1:0]  n_day;
    logic [ALM_W-1:0]  alm_sec_q, alm_min_q, alm_hour_q;
    logic              alm_hit;

    rtc_wrapctr #(.W(SEC_W), .MODULO(SEC_MOD)) u_sec (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .inc_i(tick_i),
        .ld_i(ld_en_i[FLD_SEC]), .ld_val_i(ld_val_i[SEC_W-1:0]),
        .val_o(tod_o.sec), .next_o(n_sec), .carry_o(c_sec)
    );

    rtc_wrapctr #(.W(MIN_W), .MODULO(MIN_MOD)) u_min (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .inc_i(c_sec),
        .ld_i(ld_en_i[FLD_MIN]), .ld_val_i(ld_val_i[MIN_W-1:0]),
        .val_o(tod_o.min), .next_o(n_min), .carry_o(c_min)
    );

    rtc_wrapctr #(.W(HOUR_W), .MODULO(HOUR_MOD)) u_hour (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .inc_i(c_min),
        .ld_i(ld_en_i[FLD_HOUR]), .ld_val_i(ld_val_i[HOUR_W-1:0]),
        .val_o(tod_o.hour), .next_o(n_hour), .carry_o(c_hour)
    );

    rtc_wrapctr #(.W(DAY_W), .MODULO(0)) u_day (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .inc_i(c_hour),
        .ld_i(ld_en_i[FLD_DAY]), .ld_val_i(ld_val_i[DAY_W-1:0]),
        .val_o(tod_o.day), .next_o(n_day), .carry_o(c_day)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_sec_q  <= '0;
            alm_min_q  <= '0;
            alm_hour_q <= '0;
        end else if (clr_i) begin
            alm_sec_q  <= '0;
            alm_min_q  <= '0;
            alm_hour_q <= '0;
        end else begin
            if (alm_we_i[0]) alm_sec_q  <= alm_val_i;
            if (alm_we_i[1]) alm_min_q  <= alm_val_i;
            if (alm_we_i[2]) alm_hour_q <= alm_val_i;
        end
    end

    // compare against the values the counters take at this edge
    assign alm_hit = tick_i && alm_en_i
                   && (ALM_W'(n_sec)  == alm_sec_q)
                   && (ALM_W'(n_min)  == alm_min_q)
                   && (ALM_W'(n_hour) == alm_hour_q);

    always_comb begin
        evt_o          = '0;
        evt_o[EV_SEC]  = tick_i;
        evt_o[EV_MIN]  = c_sec;
        evt_o[EV_HOUR] = c_min;
        evt_o[EV_DAY]  = c_hour;
        evt_o[EV_ALM]  = alm_hit;
    end

    assign alm_sec_o  = alm_sec_q;
    assign alm_min_o  = alm_min_q;
    assign alm_hour_o = alm_hour_q;

    // the day carry-out has no consumer; fold it into nothing observable
    logic unused_day;
    assign unused_day = c_day ^ (|n_day);

endmodule

// File: rtl/rtc_irq.sv
module rtc_irq
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_i,
    input  logic [EVT_N-1:0] en_i,
    input  logic             clr_we_i,
    input  logic [EVT_N-1:0] clr_bits_i,
    input  logic             emit_i,
    output logic [EVT_N-1:0] status_o,
    output logic [EVT_N-1:0] pulse_o,
    output logic             level_o
);

    logic [EVT_N-1:0] status_q, status_d, clr_mask;
    logic             emit_q;

    assign clr_mask = clr_we_i ? clr_bits_i : '0;
    assign status_d = (status_q & ~clr_mask) | (evt_i & en_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            emit_q   <= 1'b0;
        end else begin
            status_q <= status_d;
            emit_q   <= emit_i;
        end
    end

    genvar g;
    generate
        for (g = 0; g < EVT_N; g++) begin : g_pulse
            assign pulse_o[g] = emit_q & status_q[g] & en_i[g];
        end
    endgenerate

    assign level_o  = status_q[EV_ALM] & en_i[EV_ALM];
    assign status_o = status_q;

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tod_clear,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_alarm_lvl,
    output logic              irq_alarm_pls,
    output logic              irq_sec,
    output logic              irq_min,
    output logic              irq_hour,
    output logic              irq_day
);

    logic [CTRL_W-1:0] ctrl_q;
    logic              tick;
    logic              wr_ctrl, wr_stat, restart;
    logic [FLD_N-1:0]  ld_en;
    logic [ALM_N-1:0]  alm_we;
    tod_t              tod;
    logic [ALM_W-1:0]  alm_sec, alm_min, alm_hour;
    logic [EVT_N-1:0]  evt, status, irq_pulse;

    // write decode
    assign wr_ctrl          = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_stat          = bus_we && (bus_addr == ADDR_W'(OFS_STATUS));
    assign ld_en[FLD_SEC]   = bus_we && (bus_addr == ADDR_W'(OFS_LD_SEC));
    assign ld_en[FLD_MIN]   = bus_we && (bus_addr == ADDR_W'(OFS_LD_MIN));
    assign ld_en[FLD_HOUR]  = bus_we && (bus_addr == ADDR_W'(OFS_LD_HOUR));
    assign ld_en[FLD_DAY]   = bus_we && (bus_addr == ADDR_W'(OFS_LD_DAY));
    assign alm_we[0]        = bus_we && (bus_addr == ADDR_W'(OFS_ALM_SEC));
    assign alm_we[1]        = bus_we && (bus_addr == ADDR_W'(OFS_ALM_MIN));
    assign alm_we[2]        = bus_we && (bus_addr == ADDR_W'(OFS_ALM_HOUR));
    assign restart          = wr_ctrl && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= bus_wdata[CTRL_W-1:0];
        end
    end

    rtc_prescale #(.CLK_HZ(CLK_HZ)) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl_q[0]),
        .restart_i (restart),
        .tick_o    (tick)
    );

    rtc_timekeep u_timekeep (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (tod_clear),
        .tick_i     (tick),
        .ld_en_i    (ld_en),
        .ld_val_i   (bus_wdata),
        .alm_we_i   (alm_we),
        .alm_val_i  (bus_wdata[ALM_W-1:0]),
        .alm_en_i   (ctrl_q[EV_ALM+1]),
        .tod_o      (tod),
        .alm_sec_o  (alm_sec),
        .alm_min_o  (alm_min),
        .alm_hour_o (alm_hour),
        .evt_o      (evt)
    );

    rtc_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .en_i       (ctrl_q[CTRL_W-1:1]),
        .clr_we_i   (wr_stat),
        .clr_bits_i (bus_wdata[EVT_N-1:0]),
        .emit_i     (tick | wr_stat),
        .status_o   (status),
        .pulse_o    (irq_pulse),
        .level_o    (irq_alarm_lvl)
    );

    assign irq_sec       = irq_pulse[EV_SEC];
    assign irq_min       = irq_pulse[EV_MIN];
    assign irq_hour      = irq_pulse[EV_HOUR];
    assign irq_day       = irq_pulse[EV_DAY];
    assign irq_alarm_pls = irq_pulse[EV_ALM];

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_SEC):      bus_rdata = WORD_W'(tod.sec);
            ADDR_W'(OFS_MIN):      bus_rdata = WORD_W'(tod.min);
            ADDR_W'(OFS_HOUR):     bus_rdata = WORD_W'(tod.hour);
            ADDR_W'(OFS_DAY):      bus_rdata = tod.day;
            ADDR_W'(OFS_ALM_SEC):  bus_rdata = WORD_W'(alm_sec);
            ADDR_W'(OFS_ALM_MIN):  bus_rdata = WORD_W'(alm_min);
            ADDR_W'(OFS_ALM_HOUR): bus_rdata = WORD_W'(alm_hour);
            ADDR_W'(OFS_CTRL):     bus_rdata = WORD_W'(ctrl_q);
            ADDR_W'(OFS_STATUS):   bus_rdata = WORD_W'(status);
            ADDR_W'(OFS_REV):      bus_rdata = REV_WORD;
            ADDR_W'(OFS_PACKED):   bus_rdata = (tod.day << PK_DAY_SH)
                                             | (WORD_W'(tod.hour) << PK_HOUR_SH)
                                             | (WORD_W'(tod.min) << PK_MIN_SH)
                                             | WORD_W'(tod.sec);
            default:               bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tod_clear,
    input logic       tick,
    input logic       stat_we,
    input logic [4:0] wmask,
    input logic       ld_sec,
    input logic [5:0] ctrl,
    input logic [4:0] status,
    input logic [5:0] sec,
    input logic [4:0] pulses,
    input logic       lvl
);

    AST_NO_TICK_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |-> !tick); // R3

    AST_SEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_sec && !tod_clear) |=> (sec < 6'd60)); // R4

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_sec && !tod_clear) |=>
            (sec == (($past(sec) >= 6'd59) ? 6'd0 : ($past(sec) + 6'd1)))); // R4

    AST_SEC_STATUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(tick && ctrl[1])); // R6

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !tick) |=> ((status & $past(wmask)) == 5'd0)); // R8

    AST_ALARM_PULSE_WITH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        pulses[4] |-> lvl); // R9

    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulses) |-> $past(tick || stat_we)); // R10

endmodule

bind rtc_core rtc_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tod_clear (tod_clear),
    .tick      (tick),
    .stat_we   (wr_stat),
    .wmask     (bus_wdata[4:0]),
    .ld_sec    (ld_en[0]),
    .ctrl      (ctrl_q),
    .status    (status),
    .sec       (tod.sec),
    .pulses    (irq_pulse),
    .lvl       (irq_alarm_lvl)
);

// File: tb/rtc_core_bench.sv
`timescale 1ns/100ps
module rtc_core_bench;

    localparam int TB_HZ = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tod_clear = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_alarm_lvl, irq_alarm_pls, irq_sec, irq_min, irq_hour, irq_day;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rtc_core #(.CLK_HZ(TB_HZ), .ADDR_W(8)) u_rtc_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .tod_clear     (tod_clear),
        .bus_addr      (bus_addr),
        .bus_we        (bus_we),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq_alarm_lvl (irq_alarm_lvl),
        .irq_alarm_pls (irq_alarm_pls),
        .irq_sec       (irq_sec),
        .irq_min       (irq_min),
        .irq_hour      (irq_hour),
        .irq_day       (irq_day)
    );

    typedef struct packed {
        logic [7:0]  ls;
        logic [7:0]  lm;
        logic [7:0]  lh;
        logic [31:0] ld;
        logic [7:0]  es;
        logic [7:0]  em;
        logic [7:0]  eh;
        logic [31:0] ed;
        logic [7:0]  est;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'd5,  8'd0,  8'd0,  32'd0,          8'd6,  8'd0,  8'd0,  32'd0, 8'h01},
        '{8'd59, 8'd0,  8'd0,  32'd0,          8'd0,  8'd1,  8'd0,  32'd0, 8'h03},
        '{8'd59, 8'd59, 8'd0,  32'd0,          8'd0,  8'd0,  8'd1,  32'd0, 8'h07},
        '{8'd59, 8'd59, 8'd23, 32'd7,          8'd0,  8'd0,  8'd0,  32'd8, 8'h0F},
        '{8'd59, 8'd59, 8'd23, 32'hFFFF_FFFF,  8'd0,  8'd0,  8'd0,  32'd0, 8'h0F},
        '{8'd63, 8'd10, 8'd5,  32'd0,          8'd0,  8'd11, 8'd5,  32'd0, 8'h03},
        '{8'd30, 8'd59, 8'd10, 32'd2,          8'd31, 8'd59, 8'd10, 32'd2, 8'h01}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = 32'h0;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    function automatic logic [31:0] pack(input logic [7:0] s, input logic [7:0] m,
                                         input logic [7:0] h, input logic [31:0] d);
        return (d << 17) | ({24'h0, h} << 12) | ({24'h0, m} << 6) | {24'h0, s};
    endfunction

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] saved_st;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 sec", 8'h00, 0);
        rdchk("R1 min", 8'h04, 0);
        rdchk("R1 hour", 8'h08, 0);
        rdchk("R1 day", 8'h0C, 0);
        rdchk("R1 alarm sec", 8'h10, 0);
        rdchk("R1 alarm hour", 8'h18, 0);
        rdchk("R1 ctrl", 8'h20, 0);
        rdchk("R1 status", 8'h34, 0);
        chk("R1 outputs", {26'h0, irq_alarm_lvl, irq_alarm_pls, irq_sec, irq_min, irq_hour, irq_day}, 0);

        // R11 map corners
        rdchk("R11 revision", 8'h3C, 32'h0001_0000);
        rdchk("R11 unmapped", 8'h40, 0);
        wr(8'h00, 32'd7);
        wr(8'h40, 32'hFFFF_FFFF);
        rdchk("R11 write to read-only sec ignored", 8'h00, 0);
        rdchk("R11 unmapped after write", 8'h40, 0);
        rdchk("R11 ctrl untouched", 8'h20, 0);

        // R12 alarm register storage
        wr(8'h10, 32'h0000_01AB);
        wr(8'h14, 32'h0000_0033);
        wr(8'h18, 32'h0000_0017);
        rdchk("R12 alarm sec", 8'h10, 32'hAB);
        rdchk("R12 alarm min", 8'h14, 32'h33);
        rdchk("R12 alarm hour", 8'h18, 32'h17);

        // R5 load registers read zero
        wr(8'h24, 32'd12);
        rdchk("R5 load reg reads zero", 8'h24, 0);
        rdchk("R5 load reg sets sec", 8'h00, 12);

        // R4/R6/R10/R11 table walk: one tick per vector
        for (int i = 0; i < NV; i++) begin
            wr(8'h20, 32'h0);
            wr(8'h24, {24'h0, VECS[i].ls});
            wr(8'h28, {24'h0, VECS[i].lm});
            wr(8'h2C, {24'h0, VECS[i].lh});
            wr(8'h30, VECS[i].ld);
            wr(8'h34, 32'h1F);
            wr(8'h20, 32'h1E);
            wr(8'h20, 32'h1F);
            repeat (TB_HZ) @(posedge clk);
            #1;
            chk($sformatf("R10 vec%0d pulses", i),
                {28'h0, irq_day, irq_hour, irq_min, irq_sec}, {28'h0, VECS[i].est[3:0]});
            wr(8'h20, 32'h1E);
            rdchk($sformatf("R4 vec%0d sec", i), 8'h00, {24'h0, VECS[i].es});
            rdchk($sformatf("R4 vec%0d min", i), 8'h04, {24'h0, VECS[i].em});
            rdchk($sformatf("R4 vec%0d hour", i), 8'h08, {24'h0, VECS[i].eh});
            rdchk($sformatf("R4 vec%0d day", i), 8'h0C, VECS[i].ed);
            rdchk($sformatf("R6 vec%0d status", i), 8'h34, {24'h0, VECS[i].est});
            rdchk($sformatf("R11 vec%0d packed", i), 8'h44,
                  pack(VECS[i].es, VECS[i].em, VECS[i].eh, VECS[i].ed));
        end

        // R2 tod_clear keeps ctrl and status
        bus_addr = 8'h34;
        #0.5;
        saved_st = bus_rdata;
        wr(8'h10, 32'd33);
        wr(8'h24, 32'd44);
        @(negedge clk);
        tod_clear = 1'b1;
        @(negedge clk);
        tod_clear = 1'b0;
        rdchk("R2 sec cleared", 8'h00, 0);
        rdchk("R2 alarm cleared", 8'h10, 0);
        rdchk("R2 ctrl kept", 8'h20, 32'h1E);
        rdchk("R2 status kept", 8'h34, saved_st);

        // R10 status write re-emits pending pulses; W1C of the rest
        wr(8'h34, 32'h0000_0010);
        chk("R10 re-emit sec on status write", {31'h0, irq_sec}, 1);
        @(posedge clk);
        #1;
        chk("R10 pulse one cycle", {31'h0, irq_sec}, 0);
        wr(8'h34, 32'h0000_001F);
        chk("R8 pulses after full clear", {27'h0, irq_alarm_pls, irq_sec, irq_min, irq_hour, irq_day}, 0);
        rdchk("R8 status cleared", 8'h34, 0);

        // R3 tick timing and stop
        wr(8'h20, 32'h0);
        wr(8'h24, 32'd0);
        wr(8'h20, 32'h01);
        repeat (TB_HZ - 1) @(posedge clk);
        #1;
        rdchk("R3 no tick before period", 8'h00, 0);
        @(posedge clk);
        #1;
        rdchk("R3 first tick at period", 8'h00, 1);
        repeat (TB_HZ) @(posedge clk);
        #1;
        rdchk("R3 second tick", 8'h00, 2);
        wr(8'h20, 32'h0);
        repeat (3 * TB_HZ) @(posedge clk);
        #1;
        rdchk("R3 stopped", 8'h00, 2);

        // R6 events disabled: no status bits
        wr(8'h24, 32'd59);
        wr(8'h28, 32'd59);
        wr(8'h2C, 32'd23);
        wr(8'h20, 32'h01);
        repeat (TB_HZ) @(posedge clk);
        #1;
        wr(8'h20, 32'h0);
        rdchk("R6 disabled status", 8'h34, 0);
        rdchk("R6 disabled still rolls hour", 8'h08, 0);

        // R5 load collides with tick
        wr(8'h24, 32'd20);
        wr(8'h28, 32'd3);
        wr(8'h20, 32'h01);
        repeat (TB_HZ - 1) @(posedge clk);
        wr(8'h24, 32'd40);
        wr(8'h20, 32'h0);
        rdchk("R5 load wins over tick", 8'h00, 40);
        rdchk("R5 other field unaffected", 8'h04, 3);

        // R8 set wins over clear in the same cycle
        wr(8'h34, 32'h1F);
        wr(8'h20, 32'h03);
        repeat (TB_HZ - 1) @(posedge clk);
        wr(8'h34, 32'h01);
        wr(8'h20, 32'h02);
        rdchk("R8 set wins over clear", 8'h34, 32'h01);
        wr(8'h34, 32'h01);

        // R7/R9/R10 alarm match
        wr(8'h20, 32'h0);
        wr(8'h10, 32'd10);
        wr(8'h14, 32'd0);
        wr(8'h18, 32'd0);
        wr(8'h24, 32'd9);
        wr(8'h28, 32'd0);
        wr(8'h2C, 32'd0);
        wr(8'h20, 32'h21);
        repeat (TB_HZ) @(posedge clk);
        #1;
        chk("R10 alarm pulse", {31'h0, irq_alarm_pls}, 1);
        chk("R9 alarm level", {31'h0, irq_alarm_lvl}, 1);
        @(posedge clk);
        #1;
        chk("R10 alarm pulse drops", {31'h0, irq_alarm_pls}, 0);
        chk("R9 level holds", {31'h0, irq_alarm_lvl}, 1);
        wr(8'h20, 32'h0);
        rdchk("R7 alarm status", 8'h34, 32'h10);
        chk("R9 level masked by ctrl", {31'h0, irq_alarm_lvl}, 0);
        wr(8'h20, 32'h20);
        chk("R9 level unmasked", {31'h0, irq_alarm_lvl}, 1);
        wr(8'h34, 32'h10);
        chk("R9 level after W1C", {31'h0, irq_alarm_lvl}, 0);
        rdchk("R8 alarm bit cleared", 8'h34, 0);

        // R7 alarm disabled: no match status
        wr(8'h24, 32'd9);
        wr(8'h20, 32'h01);
        repeat (TB_HZ) @(posedge clk);
        #1;
        wr(8'h20, 32'h0);
        rdchk("R7 alarm disabled", 8'h34, 0);
        rdchk("R7 time did match", 8'h00, 10);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule